// File: doc/BRIEF.md
# Timestamp Counter with Selectable Timebase

This block keeps a free-running timestamp that software reads through a small register window. A configuration word picks one of three timebases and carries a hold bit. The count advances in nanosecond units at a fixed step per system clock, in microseconds, or in milliseconds. The block makes its own tick enables from the system clock: the default is 50 cycles per microsecond and 1000 microseconds per millisecond. In nanosecond mode the count grows by 20 on every system cycle, which matches a 50 MHz clock.

Software sets the hold bit together with the wanted timebase. While the hold bit is set the count stays at zero and both prescalers are parked. Software then writes the same timebase with the hold bit clear, and counting starts from zero. Register access uses a plain write strobe and a plain read strobe with an address. Read data is returned one cycle after the read strobe. There is no stream traffic, so no valid/ready handshake is used.

Top module: `tstamp_counter`

## Requirements
- R1: After reset the configuration reads 0 (timebase 0, hold bit clear) and `rdata` is 0 until the first read.
- R2: A write to offset 0x600 stores the timebase from `wdata[7:0]` and the hold bit from `wdata[8]` when `wdata[7:0]` is 0, 1 or 2. A read of 0x600 returns the timebase in bits 7:0, the hold bit in bit 8, and zero in all other bits.
- R3: A write to 0x600 whose `wdata[7:0]` is greater than 2 is rejected as a whole. Both the timebase and the hold bit keep their old values, and counting goes on undisturbed.
- R4: While the hold bit is set, the count reads zero and the prescalers are cleared. Take W as the clock edge that captures the write clearing the hold bit. The count is 0 just after edge W.
- R5: Timebase 0 (nanoseconds): just after edge W+k the count equals k*NS_STEP.
- R6: Timebase 1 (microseconds): just after edge W+k the count equals floor(k/CYC_PER_US).
- R7: Timebase 2 (milliseconds): just after edge W+k the count equals floor(k/(CYC_PER_US*US_PER_MS)).
- R8: The count wraps modulo 2^CNT_W. It is returned zero-extended to 32 bits.
- R9: A read strobe captured at edge R puts its data on `rdata` just after edge R, and the data holds until the next read. A read of 0x602 returns the count as it stood just before edge R. A read of any other address returns 0.
- R10: Writes to 0x602 or to any unmapped address change neither the configuration nor the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |

## Verification
A configuration write takes effect at the edge that captures it, and the counter responds to the new setting on the following edge. A read captured at edge R therefore reports the count after edge R-1, which is R-1-W cycles of counting past the releasing write at edge W. The bench numbers every clock edge. It records the edge index of each write and each read, computes the expected count from that distance and the chosen timebase, and samples `rdata` on the falling edge after the read strobe.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  localparam logic [11:0] CFG_OFS = 12'h600;
  localparam logic [11:0] CNT_OFS = 12'h602;
  localparam int unsigned SRC_MAX = 2;
  localparam int unsigned HOLD_BIT = 8;

  typedef enum logic [1:0] {
    TB_NS = 2'd0,
    TB_US = 2'd1,
    TB_MS = 2'd2
  } tb_sel_e;

  typedef struct packed {
    logic    hold;
    tb_sel_e src;
  } tsc_cfg_t;

endpackage

// File: rtl/tsc_cfg_reg.sv
module tsc_cfg_reg
  import tsc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [31:0] wdata,
  output tsc_cfg_t    cfg
);

  logic accept;

  // only legal timebase codes are taken; otherwise the whole word is dropped
  assign accept = cfg_wr && (wdata[7:0] <= 8'(SRC_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg.hold <= 1'b0;
      cfg.src  <= TB_NS;
    end else if (accept) begin
      cfg.hold <= wdata[HOLD_BIT];
      cfg.src  <= tb_sel_e'(wdata[1:0]);
    end
  end

  AST_SRC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.src != 2'd3); // R2

  AST_BAD_SRC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && wdata[7:0] > 8'(SRC_MAX)) |=> $stable(cfg)); // R3

endmodule

// File: rtl/tsc_timebase.sv
module tsc_timebase #(
  parameter int unsigned CYC_PER_US = 50,
  parameter int unsigned US_PER_MS  = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic us_tick,
  output logic ms_tick
);

  localparam int unsigned US_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam int unsigned MS_W = (US_PER_MS > 1) ? $clog2(US_PER_MS) : 1;

  generate
    if (CYC_PER_US > 1) begin : g_us_div
      logic [US_W-1:0] us_cnt;
      assign us_tick = (us_cnt == US_W'(CYC_PER_US - 1));
      always_ff @(posedge clk) begin
        if (!rst_n || clear)  us_cnt <= '0;
        else if (us_tick)     us_cnt <= '0;
        else                  us_cnt <= us_cnt + 1'b1;
      end
      AST_US_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        us_tick |=> !us_tick); // R6
    end else begin : g_us_pass
      assign us_tick = !clear;
    end

    if (US_PER_MS > 1) begin : g_ms_div
      logic [MS_W-1:0] ms_cnt;
      logic            ms_wrap;
      assign ms_wrap = (ms_cnt == MS_W'(US_PER_MS - 1));
      assign ms_tick = us_tick && ms_wrap;
      always_ff @(posedge clk) begin
        if (!rst_n || clear)  ms_cnt <= '0;
        else if (ms_tick)     ms_cnt <= '0;
        else if (us_tick)     ms_cnt <= ms_cnt + 1'b1;
      end
    end else begin : g_ms_pass
      assign ms_tick = us_tick;
    end
  endgenerate

  AST_MS_NEEDS_US: assert property (@(posedge clk) disable iff (!rst_n)
    ms_tick |-> us_tick); // R7

endmodule

// File: rtl/tsc_accum.sv
module tsc_accum
  import tsc_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned NS_STEP = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tsc_cfg_t         cfg,
  input  logic             us_tick,
  input  logic             ms_tick,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] STEP = CNT_W'(NS_STEP);

  logic [CNT_W-1:0] incr;

  always_comb begin
    incr = '0;
    unique case (cfg.src)
      TB_NS:   incr = STEP;
      TB_US:   incr = us_tick ? CNT_W'(1) : '0;
      TB_MS:   incr = ms_tick ? CNT_W'(1) : '0;
      default: incr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cfg.hold) count <= '0;
    else                    count <= count + incr;
  end

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.hold |=> count == '0); // R4

  AST_NS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.hold && cfg.src == TB_NS) |=> count == $past(count) + STEP); // R5

  AST_US_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.hold && cfg.src == TB_US && !us_tick) |=> $stable(count)); // R6

  AST_MS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.hold && cfg.src == TB_MS && !ms_tick) |=> $stable(count)); // R7

endmodule

// File: rtl/tstamp_counter.sv
module tstamp_counter
  import tsc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned NS_STEP    = 20,
  parameter int unsigned CYC_PER_US = 50,
  parameter int unsigned US_PER_MS  = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata
);

  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(CFG_OFS);
  localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(CNT_OFS);

  tsc_cfg_t         cfg;
  logic             us_tick;
  logic             ms_tick;
  logic [CNT_W-1:0] count;
  logic [31:0]      rd_mux;
  logic             hit_cfg;
  logic             hit_cnt;

  assign hit_cfg = (addr == A_CFG);
  assign hit_cnt = (addr == A_CNT);

  tsc_cfg_reg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_wr (wr_en && hit_cfg),
    .wdata  (wdata),
    .cfg    (cfg)
  );

  tsc_timebase #(
    .CYC_PER_US (CYC_PER_US),
    .US_PER_MS  (US_PER_MS)
  ) u_tb (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (cfg.hold),
    .us_tick (us_tick),
    .ms_tick (ms_tick)
  );

  tsc_accum #(
    .CNT_W   (CNT_W),
    .NS_STEP (NS_STEP)
  ) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg     (cfg),
    .us_tick (us_tick),
    .ms_tick (ms_tick),
    .count   (count)
  );

  always_comb begin
    rd_mux = '0;
    if (hit_cfg) begin
      rd_mux[HOLD_BIT] = cfg.hold;
      rd_mux[1:0]      = cfg.src;
    end else if (hit_cnt) begin
      rd_mux = 32'(count);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit_cfg && !hit_cnt) |=> rdata == '0); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R9

  AST_CNT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit_cfg) |=> $stable(cfg)); // R10

endmodule

// File: tb/test_tstamp_counter.sv
module test_tstamp_counter;

  localparam int unsigned ADDR_W = 12;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned STEP   = 20;
  localparam int unsigned NUS    = 5;
  localparam int unsigned NMS    = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;

  int unsigned cyc = 0;
  int errors = 0;
  int checks = 0;
  int unsigned rel_edge;
  int unsigned cur_src;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tstamp_counter #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NS_STEP(STEP),
    .CYC_PER_US(NUS), .US_PER_MS(NMS)
  ) i_tstamp_counter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  function automatic logic [31:0] exp_cnt(input int unsigned src, input int unsigned k);
    longint unsigned v;
    if (src == 0)      v = longint'(k) * STEP;
    else if (src == 1) v = k / NUS;
    else               v = k / (NUS * NMS);
    return 32'(v % (64'd1 << CNT_W));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, output int unsigned e);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; e = cyc + 1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] v, output int unsigned e);
    @(negedge clk);
    rd_en = 1'b1; addr = a; e = cyc + 1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic release_src(input int unsigned src);
    int unsigned e;
    logic [31:0] v;
    wr(12'h600, 32'h100 | src, e);
    repeat (3) @(negedge clk);
    rd(12'h602, v, e);
    check("R4 held count", v, 32'h0);
    rd(12'h600, v, e);
    check("R2 cfg readback", v, 32'h100 | src);
    wr(12'h600, src, rel_edge);
    cur_src = src;
  endtask

  task automatic read_count(input string req);
    int unsigned e;
    logic [31:0] v;
    rd(12'h602, v, e);
    check(req, v, exp_cnt(cur_src, e - 1 - rel_edge));
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int unsigned e;
    logic [31:0] v;
    void'($urandom(32'd11));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata after reset", rdata, 32'h0);
    rd(12'h600, v, e);
    check("R1 cfg after reset", v, 32'h0);

    for (int s = 0; s < 3; s++) begin
      release_src(s);
      repeat (30 + s * 20) @(negedge clk);
      read_count(s == 0 ? "R5 ns" : (s == 1 ? "R6 us" : "R7 ms"));
    end

    for (int i = 0; i < 20; i++) begin
      int unsigned s;
      s = $urandom % 3;
      release_src(s);
      repeat ($urandom % 80) @(negedge clk);
      read_count(s == 0 ? "R5 ns random" : (s == 1 ? "R6 us random" : "R7 ms random"));
    end

    // illegal timebase codes, one with the hold bit set
    release_src(1);
    repeat (7) @(negedge clk);
    wr(12'h600, 32'h103, e);
    wr(12'h600, 32'h0FF, e);
    rd(12'h600, v, e);
    check("R3 cfg unchanged", v, 32'h1);
    read_count("R3 count undisturbed");

    // writes outside the config register
    release_src(0);
    wr(12'h602, 32'h100, e);
    wr(12'h044, 32'h102, e);
    rd(12'h600, v, e);
    check("R10 cfg unchanged", v, 32'h0);
    read_count("R10 count undisturbed");

    rd(12'h010, v, e);
    check("R9 unmapped read", v, 32'h0);
    repeat (2) @(negedge clk);
    check("R9 rdata holds", rdata, 32'h0);

    // wrap: 20 per cycle over a 16-bit count
    release_src(0);
    repeat (3400) @(negedge clk);
    read_count("R8 wrap");

    release_src(2);
    repeat (95) @(negedge clk);
    read_count("R7 ms long");

    finish_run();
  end

endmodule